// File: doc/BRIEF.md
# Twin-Predicated Element Loop Sequencer

This block steps through the element groups of a single vectorised operation. A start pulse captures the group count, the sub-vector length, the predication mode and field, the three predicate register values and the two base register numbers. From then on the block issues at most one element operation per cycle. Each operation carries a source register number, a destination register number and a sub-element index. A single-cycle done pulse ends the operation. A downstream stall input freezes the sequencer and holds its outputs.

Predication acts on whole sub-vector groups. The source index and the destination index each skip groups whose mask bit is clear, and they do so independently of each other. A skip costs no cycles. Each operand has a scalar/vector flag. A scalar operand repeats its base register number. A vector operand adds the group index to its base. When a predicate is applied to a scalar operand, the loop stops after the first group that is issued. This gives splat and select behaviour.

Top module: `twinpred_seq`

## Requirements
- R1: After reset, `op_valid` and `op_done` are low. A start pulse is accepted only when the block is idle, and it captures every configuration input, including the three predicate values. Inputs that change after the capture have no effect on the operation.
- R2: The sub-vector length code `svl` gives `svl`+1 sub-elements per group, so code 00 means one sub-element. Every issued group produces exactly that many operations, one per issue slot, with `op_sub` counting 0, 1, ... in order. Source and destination numbers are the same for every operation within a group.
- R3: The register number of an operand whose flag is 0 (scalar) equals its base on every operation. An operand whose flag is 1 (vector) gets base plus group index, modulo 128.
- R4: With `twin`=0, the field `pfield` chooses one mask that serves both source and destination. 000 and 001 mean unpredicated. 01x selects predicate register 9, 10x selects register 10 and 11x selects register 11. Bit 0 set uses the register as is, and bit 0 clear uses its complement.
- R5: With `twin`=1, field bit 0 enables a source mask taken from predicate register 9, and field bit 1 enables a destination mask taken from predicate register 10. Field bit 2 complements the enabled masks. A mask that is not enabled is all ones, so 000 and 100 are unpredicated.
- R6: Bit g of a mask governs whole group g. A group whose bit is clear issues none of its sub-elements. The source index and the destination index each move on to the next group whose bit is set in their own mask, and they advance together after every issued group.
- R7: If an operand is scalar and its mask is enabled (R4/R5), the operation ends after the first issued group.
- R8: The operation ends as soon as either index reaches `vl`. `op_done` then pulses for one accepted cycle, after the last operation, and is never high together with `op_valid`. When `vl`=0 or a mask has no set bit below `vl`, done comes with no operations issued.
- R9: While `stall` is high, `op_valid`, `op_src`, `op_dst`, `op_sub` and `op_done` hold their values. An operation counts as accepted in a cycle where `op_valid` is high and `stall` is low.
- R10: A start pulse that arrives while an operation is running is ignored, along with the configuration that comes with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation; ignored while busy |
| twin | input | 1 | 0 single predication, 1 twin predication |
| pfield | input | 3 | Predicate field, decoded per R4/R5 |
| svl | input | 2 | Sub-vector length code (length = code+1) |
| vl | input | IW | Number of element groups, 0..MAXVL |
| src_vec | input | 1 | Source operand is a vector (1) or scalar (0) |
| dst_vec | input | 1 | Destination operand is a vector (1) or scalar (0) |
| src_base | input | 7 | Source base register number |
| dst_base | input | 7 | Destination base register number |
| pr9 | input | MAXVL | Value of predicate register 9 |
| pr10 | input | MAXVL | Value of predicate register 10 |
| pr11 | input | MAXVL | Value of predicate register 11 |
| stall | input | 1 | Downstream stall; freezes the sequencer |
| op_valid | output | 1 | An element operation is presented |
| op_src | output | 7 | Source register number |
| op_dst | output | 7 | Destination register number |
| op_sub | output | 2 | Sub-element index within the group |
| op_done | output | 1 | Operation complete pulse |

## Verification
The sweep covers both predication modes, all eight field values, every sub-vector length and every scalar/vector pairing. It also drives group counts of zero, partial and full, and uses sparse and dense predicate patterns. A design that skipped only one index, or reset both indices to a shared position, would pair the wrong source and destination groups. A design that predicated individual sub-elements, or missed the scalar stop rule, would issue too many or too few operations. Runs with pseudo-random stall expose a sequencer that advances while stalled, because an operation goes missing. Each run also re-raises start with scrambled inputs one cycle after the real start, which catches a block that re-captures while busy. Base numbers near 127 check the register-number wrap.

// File: rtl/tps_pkg.sv
package tps_pkg;
  localparam int REGW = 7;
  localparam int SUBW = 2;

  typedef logic [REGW-1:0] regnum_t;
  typedef logic [SUBW-1:0] subidx_t;
endpackage

// File: rtl/tps_mask_sel.sv
module tps_mask_sel #(
  parameter int MAXVL = 16
) (
  input  logic             twin,
  input  logic [2:0]       pfield,
  input  logic [MAXVL-1:0] p9,
  input  logic [MAXVL-1:0] p10,
  input  logic [MAXVL-1:0] p11,
  output logic [MAXVL-1:0] smask,
  output logic [MAXVL-1:0] dmask,
  output logic             s_act,
  output logic             d_act
);
  logic [MAXVL-1:0] pick;

  always_comb begin
    unique case (pfield[2:1])
      2'b01:   pick = p9;
      2'b10:   pick = p10;
      default: pick = p11;
    endcase
  end

  always_comb begin
    if (twin) begin
      s_act = pfield[0];
      d_act = pfield[1];
      smask = s_act ? (pfield[2] ? ~p9  : p9)  : '1;
      dmask = d_act ? (pfield[2] ? ~p10 : p10) : '1;
    end else if (pfield[2:1] == 2'b00) begin
      s_act = 1'b0;
      d_act = 1'b0;
      smask = '1;
      dmask = '1;
    end else begin
      s_act = 1'b1;
      d_act = 1'b1;
      smask = pfield[0] ? pick : ~pick;
      dmask = smask;
    end
  end
endmodule

// File: rtl/tps_first_set.sv
module tps_first_set #(
  parameter int N  = 16,
  parameter int IW = $clog2(N + 1)
) (
  input  logic [N-1:0]  vec,
  input  logic [IW-1:0] from,
  input  logic [IW-1:0] lim,
  output logic          found,
  output logic [IW-1:0] pos
);
  logic [N-1:0] elig;

  for (genvar g = 0; g < N; g++) begin : g_elig
    localparam logic [IW-1:0] GI = IW'(g);
    assign elig[g] = vec[g] && (GI >= from) && (GI < lim);
  end

  always_comb begin
    found = 1'b0;
    pos   = '0;
    for (int b = N - 1; b >= 0; b--) begin
      if (elig[b]) begin
        found = 1'b1;
        pos   = IW'(b);
      end
    end
  end
endmodule

// File: rtl/twinpred_seq.sv
module twinpred_seq
  import tps_pkg::*;
#(
  parameter int MAXVL = 16,
  localparam int IW   = $clog2(MAXVL + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                twin,
  input  logic [2:0]          pfield,
  input  logic [SUBW-1:0]     svl,
  input  logic [IW-1:0]       vl,
  input  logic                src_vec,
  input  logic                dst_vec,
  input  logic [REGW-1:0]     src_base,
  input  logic [REGW-1:0]     dst_base,
  input  logic [MAXVL-1:0]    pr9,
  input  logic [MAXVL-1:0]    pr10,
  input  logic [MAXVL-1:0]    pr11,
  input  logic                stall,
  output logic                op_valid,
  output logic [REGW-1:0]     op_src,
  output logic [REGW-1:0]     op_dst,
  output logic [SUBW-1:0]     op_sub,
  output logic                op_done
);
  localparam logic [IW-1:0] END_IDX = IW'(MAXVL);

  // captured configuration
  logic             c_twin, c_sv, c_dv;
  logic [2:0]       c_pf;
  subidx_t          c_svl;
  logic [IW-1:0]    c_vl;
  regnum_t          c_sb, c_db;
  logic [MAXVL-1:0] c_p9, c_p10, c_p11;

  // loop state
  logic             busy;
  logic [IW-1:0]    si, di;   // next candidate group per side
  logic [IW-1:0]    gs, gd;   // group currently being issued
  subidx_t          k;        // next sub-element to issue

  logic [MAXVL-1:0] smask, dmask;
  logic             s_act, d_act, stop_after;
  logic             s_found, d_found;
  logic [IW-1:0]    s_pos, d_pos;

  tps_mask_sel #(.MAXVL(MAXVL)) u_mask (
    .twin(c_twin), .pfield(c_pf), .p9(c_p9), .p10(c_p10), .p11(c_p11),
    .smask(smask), .dmask(dmask), .s_act(s_act), .d_act(d_act)
  );

  tps_first_set #(.N(MAXVL), .IW(IW)) u_src_find (
    .vec(smask), .from(si), .lim(c_vl), .found(s_found), .pos(s_pos)
  );

  tps_first_set #(.N(MAXVL), .IW(IW)) u_dst_find (
    .vec(dmask), .from(di), .lim(c_vl), .found(d_found), .pos(d_pos)
  );

  assign stop_after = (s_act && !c_sv) || (d_act && !c_dv);

  function automatic regnum_t reg_of(input regnum_t base, input logic vec,
                                     input logic [IW-1:0] grp);
    return vec ? regnum_t'(base + regnum_t'(grp)) : base;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      op_valid <= 1'b0;
      op_done  <= 1'b0;
      op_src   <= '0;
      op_dst   <= '0;
      op_sub   <= '0;
      si       <= '0;
      di       <= '0;
      gs       <= '0;
      gd       <= '0;
      k        <= '0;
      c_twin   <= 1'b0;
      c_sv     <= 1'b0;
      c_dv     <= 1'b0;
      c_pf     <= '0;
      c_svl    <= '0;
      c_vl     <= '0;
      c_sb     <= '0;
      c_db     <= '0;
      c_p9     <= '0;
      c_p10    <= '0;
      c_p11    <= '0;
    end else if (!busy) begin
      if (!stall) begin
        op_valid <= 1'b0;
        op_done  <= 1'b0;
      end
      if (start) begin
        busy   <= 1'b1;
        c_twin <= twin;
        c_pf   <= pfield;
        c_svl  <= svl;
        c_vl   <= vl;
        c_sv   <= src_vec;
        c_dv   <= dst_vec;
        c_sb   <= src_base;
        c_db   <= dst_base;
        c_p9   <= pr9;
        c_p10  <= pr10;
        c_p11  <= pr11;
        si     <= '0;
        di     <= '0;
        k      <= '0;
      end
    end else if (!stall) begin
      if (k == '0) begin
        if (!s_found || !d_found) begin
          op_valid <= 1'b0;
          op_done  <= 1'b1;
          busy     <= 1'b0;
        end else begin
          op_valid <= 1'b1;
          op_src   <= reg_of(c_sb, c_sv, s_pos);
          op_dst   <= reg_of(c_db, c_dv, d_pos);
          op_sub   <= '0;
          gs       <= s_pos;
          gd       <= d_pos;
          if (c_svl == '0) begin
            si <= stop_after ? END_IDX : s_pos + 1'b1;
            di <= stop_after ? END_IDX : d_pos + 1'b1;
          end else begin
            k <= subidx_t'(1);
          end
        end
      end else begin
        op_valid <= 1'b1;
        op_sub   <= k;
        if (k == c_svl) begin
          k  <= '0;
          si <= stop_after ? END_IDX : gs + 1'b1;
          di <= stop_after ? END_IDX : gd + 1'b1;
        end else begin
          k <= k + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tps_checker.sv
module tps_checker
  import tps_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          stall,
  input logic          op_valid,
  input logic          op_done,
  input logic [REGW-1:0] op_src,
  input logic [REGW-1:0] op_dst,
  input logic [SUBW-1:0] op_sub,
  input logic [SUBW-1:0] cfg_svl
);
  // R9: a stalled operation stays presented unchanged
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (op_valid && stall) |=> (op_valid && $stable(op_src) && $stable(op_dst) && $stable(op_sub)));

  // R8: done lasts one accepted cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    (op_done && !stall) |=> !op_done);

  // R8: done and an operation never coincide
  a_r8_done_excl: assert property (@(posedge clk) disable iff (rst)
    !(op_valid && op_done));

  // R2: sub-element index stays within the captured length
  a_r2_sub_range: assert property (@(posedge clk) disable iff (rst)
    op_valid |-> (op_sub <= cfg_svl));

  // R2: within a group the next slot carries the next sub-element, same registers
  a_r2_sub_step: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !stall && (op_sub != cfg_svl)) |=>
      (op_valid && (op_sub == SUBW'($past(op_sub) + 1'b1)) &&
       (op_src == $past(op_src)) && (op_dst == $past(op_dst))));
endmodule

bind twinpred_seq tps_checker u_chk (
  .clk(clk), .rst(rst), .stall(stall),
  .op_valid(op_valid), .op_done(op_done),
  .op_src(op_src), .op_dst(op_dst), .op_sub(op_sub),
  .cfg_svl(c_svl)
);

// File: tb/twinpred_seq_test.sv
module twinpred_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAXVL = 8;
  localparam int IW = $clog2(MAXVL + 1);
  localparam logic [6:0] SB = 7'd125;
  localparam logic [6:0] DB = 7'd5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, twin = 1'b0, src_vec = 1'b0, dst_vec = 1'b0, stall = 1'b0;
  logic [2:0] pfield = '0;
  logic [1:0] svl = '0;
  logic [IW-1:0] vl = '0;
  logic [6:0] src_base = '0, dst_base = '0;
  logic [MAXVL-1:0] pr9 = '0, pr10 = '0, pr11 = '0;
  logic op_valid, op_done;
  logic [6:0] op_src, op_dst;
  logic [1:0] op_sub;

  int vectors = 0;
  int fails = 0;
  bit finished = 0;
  logic [15:0] lf = 16'hACE1;

  logic [6:0] es [0:63];
  logic [6:0] ed [0:63];
  logic [1:0] ek [0:63];
  int en;
  logic [6:0] gsr [0:63];
  logic [6:0] gds [0:63];
  logic [1:0] gk [0:63];
  int gn;

  always #(CLK_PERIOD/2) clk = ~clk;

  twinpred_seq #(.MAXVL(MAXVL)) uut (
    .clk(clk), .rst(rst), .start(start), .twin(twin), .pfield(pfield),
    .svl(svl), .vl(vl), .src_vec(src_vec), .dst_vec(dst_vec),
    .src_base(src_base), .dst_base(dst_base),
    .pr9(pr9), .pr10(pr10), .pr11(pr11), .stall(stall),
    .op_valid(op_valid), .op_src(op_src), .op_dst(op_dst),
    .op_sub(op_sub), .op_done(op_done)
  );

  // Expected operation list, built from R2..R8
  task automatic model(input logic tw, input logic [2:0] f, input logic [1:0] s,
                       input logic sv, input logic dv, input int v,
                       input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    logic [7:0] sm, dm, sel;
    logic sa, da, stp;
    int i, j;
    if (tw) begin                                   // R5
      sa = f[0]; da = f[1];
      sm = sa ? (f[2] ? ~a : a) : 8'hFF;
      dm = da ? (f[2] ? ~b : b) : 8'hFF;
    end else if (f[2:1] == 2'b00) begin             // R4 unpredicated
      sa = 0; da = 0; sm = 8'hFF; dm = 8'hFF;
    end else begin                                  // R4 register choice
      sel = (f[2:1] == 2'b01) ? a : (f[2:1] == 2'b10) ? b : c;
      sm = f[0] ? sel : ~sel;
      dm = sm; sa = 1; da = 1;
    end
    stp = (sa && !sv) || (da && !dv);               // R7
    en = 0; i = 0; j = 0;
    forever begin
      while (i < v && !sm[i]) i++;                  // R6
      while (j < v && !dm[j]) j++;
      if (i >= v || j >= v) break;                  // R8
      for (int k = 0; k <= int'(s); k++) begin      // R2
        es[en] = sv ? 7'(SB + 7'(i)) : SB;          // R3
        ed[en] = dv ? 7'(DB + 7'(j)) : DB;
        ek[en] = 2'(k);
        en++;
      end
      if (stp) break;
      i++; j++;
    end
  endtask

  task automatic run(input logic tw, input logic [2:0] f, input logic [1:0] s,
                     input logic sv, input logic dv, input int v,
                     input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                     input bit se);
    int dn;
    bit fin, bad;
    model(tw, f, s, sv, dv, v, a, b, c);
    @(negedge clk);
    start = 1; twin = tw; pfield = f; svl = s; vl = IW'(v);
    src_vec = sv; dst_vec = dv; src_base = SB; dst_base = DB;
    pr9 = a; pr10 = b; pr11 = c; stall = 0;
    @(negedge clk);
    // R10 / R1: second start while busy, with scrambled inputs
    twin = ~tw; pfield = ~f; svl = ~s; vl = IW'(MAXVL); src_vec = ~sv; dst_vec = ~dv;
    src_base = 7'd64; dst_base = 7'd99; pr9 = ~a; pr10 = ~b; pr11 = ~c;
    @(negedge clk);
    start = 0;
    gn = 0; dn = 0; fin = 0;
    for (int cyc = 0; cyc < 400; cyc++) begin
      if (op_valid && !stall) begin
        if (gn < 64) begin gsr[gn] = op_src; gds[gn] = op_dst; gk[gn] = op_sub; end
        gn++;
      end
      if (op_done && !stall) begin dn++; fin = 1; end
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      stall = fin ? 1'b0 : (se ? (lf[0] & lf[3]) : 1'b0);
      if (fin) break;
      @(negedge clk);
    end
    @(negedge clk);
    if (op_done || op_valid) dn++;
    // R2 R3 R4 R5 R6 R7 R9 R10: full operation list
    vectors++;
    bad = (gn != en);
    for (int q = 0; q < en && q < gn; q++)
      if (gsr[q] !== es[q] || gds[q] !== ed[q] || gk[q] !== ek[q]) bad = 1;
    if (bad) begin
      fails++;
      $display("FAIL R2 R3 R6 R7 R9 R10 %s twin=%0d f=%b svl=%0d sv=%0d dv=%0d vl=%0d: got %0d ops (first %0d/%0d/%0d) expected %0d ops (first %0d/%0d/%0d)",
               tw ? "R5" : "R4", tw, f, s, sv, dv, v, gn, gsr[0], gds[0], gk[0],
               en, es[0], ed[0], ek[0]);
    end
    // R8: exactly one done pulse
    vectors++;
    if (dn != 1) begin
      fails++;
      $display("FAIL R8 done pulses twin=%0d f=%b vl=%0d: got %0d expected 1", tw, f, v, dn);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int vls [3];
    logic [7:0] pa [2], pb [2], pc [2];
    vls = '{0, 3, 8};
    pa = '{8'b1011_0010, 8'b0000_0100};
    pb = '{8'b0110_1101, 8'hFF};
    pc = '{8'b1100_0101, 8'b0000_0001};
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    vectors++;
    if (op_valid !== 1'b0) begin fails++; $display("FAIL R1 op_valid after reset: got %b expected 0", op_valid); end
    vectors++;
    if (op_done !== 1'b0) begin fails++; $display("FAIL R1 op_done after reset: got %b expected 0", op_done); end
    for (int tw = 0; tw < 2; tw++)
      for (int f = 0; f < 8; f++)
        for (int s = 0; s < 4; s++)
          for (int fl = 0; fl < 4; fl++)
            for (int vi = 0; vi < 3; vi++)
              for (int p = 0; p < 2; p++)
                run(tw[0], 3'(f), 2'(s), fl[0], fl[1], vls[vi], pa[p], pb[p], pc[p],
                    ((f + s + vi + p) % 2) == 1);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule